// File: doc/BRIEF.md
# Bus-Cycle Instruction Framer

This block listens to a 6502-family processor bus on which only the data byte and three control strobes are visible: read/write direction, the opcode-fetch marker and the ready (wait) line. No address lines are connected. The processor's phase-2 clock is the cycle reference. Once per bus cycle, on the phase-2 high-to-low transition, the block captures the bus. It then cuts the stream of cycles into whole instructions.

Each instruction starts at a cycle that carries the fetch marker. Every cycle that follows, up to the next fetch, belongs to that instruction. Cycles held by the ready line are dropped.

When the next fetch arrives, the finished instruction is released as one record. The record holds:
- the opcode;
- the bytes and directions of the stored cycles;
- the cycle count;
- an overflow mark;
- a classification. A run of three stacked writes marks a hardware interrupt. When the opcode is zero, the same run marks a software break instead.

Records leave through a valid/ready handshake. The output stage keeps one extra finished record behind the one on offer, so a short consumer stall loses nothing.

Top module: `bus_instr_framer`

## Requirements
- R1: One bus sample is taken per high-to-low transition of `phi2`, using the values present on that transition. While `phi2` holds its level, changes on the other bus inputs have no effect.
- R2: A sample with `bus_sync`=1 and `bus_rdy`=1 opens a new instruction. The fetched byte becomes the opcode and is stored as cycle 0 in `rec_data[7:0]`, with its direction in `rec_rnw[0]`.
- R3: Each later sample with `bus_rdy`=1 is appended in order. Stored cycle i sits at `rec_data[8i+7:8i]`, and `rec_rnw[i]` is its `bus_rnw` level (1 = read). `rec_count` equals the fetch cycle plus the appended cycles.
- R4: A sample with `bus_rdy`=0 is a wait state. It is not stored and not counted. It neither opens an instruction nor breaks a run of writes, even when `bus_sync` is 1.
- R5: If the instruction contains three consecutive stored write cycles (`bus_rnw`=0), the record sets `rec_irq`=1. The exception is opcode 0x00, which sets `rec_brk`=1 instead. Otherwise both are 0, and the two are never set together.
- R6: A record is released only by the next opening fetch sample. With the output stage empty, `rec_valid` rises on the clk edge after the one at which `phi2` is first seen low in that fetch cycle.
- R7: At most MAX_CYC (default 8) cycles are stored. Further cycles set `rec_ovf`=1 and leave `rec_count`=MAX_CYC and the stored bytes unchanged.
- R8: After reset `rec_valid`=0. Samples taken before the first opening fetch are dropped, and no record is produced for them.
- R9: While `rec_valid`=1 and `rec_ready`=0, the offered record stays valid and unchanged. One further finished record is held behind it, and records leave in completion order.
- R10: A record that finishes while both the offered slot and the holding slot are full is discarded. The two stored records are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than phi2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Processor phase-2 clock, synchronous to clk |
| bus_data | input | DW | Processor data bus |
| bus_rnw | input | 1 | Bus direction, 1 = read |
| bus_sync | input | 1 | Opcode-fetch marker |
| bus_rdy | input | 1 | Ready line, 0 = wait state |
| rec_ready | input | 1 | Consumer accepts the offered record |
| rec_valid | output | 1 | A record is offered |
| rec_opcode | output | DW | Opcode of the offered record |
| rec_data | output | MAX_CYC*DW | Stored cycle bytes, cycle 0 in the low byte |
| rec_rnw | output | MAX_CYC | Stored cycle directions, 1 = read |
| rec_count | output | $clog2(MAX_CYC+1) | Number of stored cycles |
| rec_irq | output | 1 | Hardware interrupt recognised |
| rec_brk | output | 1 | Software break recognised |
| rec_ovf | output | 1 | More cycles arrived than could be stored |

## Verification
The result paths are short and fixed. A bus sample is registered on the clk edge that first sees `phi2` low. On the following edge, the record finished by a fetch sample lands in the output register, so it is visible two edges after the `phi2` fall. The bench checks this latency directly, sampling `rec_valid` on the falling clk edge between those two rising edges (expected 0) and just after the second one (expected 1). All other records are compared by a scoreboard. The scoreboard compares each record on the falling clk edge at which both valid and ready are high, so every compare happens one half period before the transfer. A stall scenario checks that the offered record holds still, that the held record follows it, and that the record finishing into full slots never appears.

// File: rtl/framer_pkg.sv
package framer_pkg;

   typedef enum logic [1:0] {
      REC_PLAIN = 2'd0,
      REC_HWIRQ = 2'd1,
      REC_SWBRK = 2'd2
   } rec_kind_e;

   localparam logic [7:0] OPC_SWBRK = 8'h00;
   localparam int         PUSH_RUN  = 3;

   function automatic rec_kind_e classify(input logic run_hit, input logic [7:0] opc);
      if (!run_hit)
         return REC_PLAIN;
      return (opc == OPC_SWBRK) ? REC_SWBRK : REC_HWIRQ;
   endfunction

endpackage

// File: rtl/framer_sample.sv
module framer_sample #(
   parameter int DW             = 8,
   parameter bit SAMPLE_ON_FALL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          phi2,
   input  logic [DW-1:0] bus_data,
   input  logic          bus_rnw,
   input  logic          bus_sync,
   input  logic          bus_rdy,
   output logic          smp_vld,
   output logic [DW-1:0] smp_data,
   output logic          smp_rnw,
   output logic          smp_sync,
   output logic          smp_rdy
);

   logic phi2_q;
   logic strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phi2_q <= ~SAMPLE_ON_FALL;
      else        phi2_q <= phi2;
   end

   generate
      if (SAMPLE_ON_FALL) begin : g_fall
         assign strobe = phi2_q & ~phi2;
      end else begin : g_rise
         assign strobe = ~phi2_q & phi2;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_vld  <= 1'b0;
         smp_data <= '0;
         smp_rnw  <= 1'b1;
         smp_sync <= 1'b0;
         smp_rdy  <= 1'b0;
      end else begin
         smp_vld <= strobe;
         if (strobe) begin
            smp_data <= bus_data;
            smp_rnw  <= bus_rnw;
            smp_sync <= bus_sync;
            smp_rdy  <= bus_rdy;
         end
      end
   end

   assert_single_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld |=> !smp_vld);

endmodule

// File: rtl/framer_assemble.sv
module framer_assemble
   import framer_pkg::*;
#(
   parameter int DW      = 8,
   parameter int MAX_CYC = 8,
   parameter int CW      = $clog2(MAX_CYC + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  smp_vld,
   input  logic [DW-1:0]         smp_data,
   input  logic                  smp_rnw,
   input  logic                  smp_sync,
   input  logic                  smp_rdy,
   output logic                  fin_vld,
   output logic [MAX_CYC*DW-1:0] fin_data,
   output logic [MAX_CYC-1:0]    fin_rnw,
   output logic [CW-1:0]         fin_count,
   output rec_kind_e             fin_kind,
   output logic                  fin_ovf
);

   localparam int                RUN_W   = $clog2(PUSH_RUN + 1);
   localparam logic [RUN_W-1:0]  RUN_TOP = RUN_W'(PUSH_RUN);
   localparam logic [CW-1:0]     CNT_TOP = CW'(MAX_CYC);

   logic             active;
   logic [CW-1:0]    cnt;
   logic             ovf;
   logic [RUN_W-1:0] run;
   logic             hit;
   logic             take, open, append, room;

   assign take   = smp_vld & smp_rdy;
   assign open   = take & smp_sync;
   assign append = take & ~smp_sync & active;
   assign room   = (cnt < CNT_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         ovf    <= 1'b0;
         run    <= '0;
         hit    <= 1'b0;
      end else if (open) begin
         active <= 1'b1;
         cnt    <= CW'(1);
         ovf    <= 1'b0;
         run    <= '0;
         hit    <= 1'b0;
      end else if (append) begin
         if (room) cnt <= cnt + 1'b1;
         else      ovf <= 1'b1;
         if (smp_rnw) begin
            run <= '0;
         end else begin
            if (run != RUN_TOP)        run <= run + 1'b1;
            if (run == RUN_TOP - 1'b1) hit <= 1'b1;
         end
      end
   end

   generate
      for (genvar g = 0; g < MAX_CYC; g++) begin : g_slot
         logic [DW-1:0] byte_q;
         logic          dir_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               byte_q <= '0;
               dir_q  <= 1'b0;
            end else if (open) begin
               byte_q <= (g == 0) ? smp_data : '0;
               dir_q  <= (g == 0) ? smp_rnw  : 1'b0;
            end else if (append && room && cnt == CW'(g)) begin
               byte_q <= smp_data;
               dir_q  <= smp_rnw;
            end
         end
         assign fin_data[g*DW +: DW] = byte_q;
         assign fin_rnw[g]           = dir_q;
      end
   endgenerate

   assign fin_vld   = open & active;
   assign fin_count = cnt;
   assign fin_ovf   = ovf;
   assign fin_kind  = classify(hit, fin_data[7:0]);

   assert_wait_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !smp_rdy) |=> ($stable(cnt) && $stable(run) && $stable(hit) && $stable(active)));

   assert_cap_reached_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> (cnt == CNT_TOP));

   assert_first_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> (cnt == CW'(1)));

endmodule

// File: rtl/framer_outq.sv
module framer_outq #(
   parameter int W        = 16,
   parameter bit USE_HOLD = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_dat,
   input  logic         ready,
   output logic         valid,
   output logic [W-1:0] dat
);

   logic         o_vld;
   logic [W-1:0] o_dat;
   logic         pop;

   assign pop = o_vld & ready;

   generate
      if (USE_HOLD) begin : g_hold
         logic         h_vld;
         logic [W-1:0] h_dat;
         logic         o_busy, h_busy;

         always_comb begin
            o_busy = (o_vld & ~pop) | (pop & h_vld);
            h_busy = h_vld & ~pop;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               o_vld <= 1'b0;
               o_dat <= '0;
               h_vld <= 1'b0;
               h_dat <= '0;
            end else begin
               if (pop) begin
                  o_vld <= h_vld;
                  if (h_vld) o_dat <= h_dat;
                  h_vld <= 1'b0;
               end
               if (push) begin
                  if (!o_busy) begin
                     o_vld <= 1'b1;
                     o_dat <= push_dat;
                  end else if (!h_busy) begin
                     h_vld <= 1'b1;
                     h_dat <= push_dat;
                  end
               end
            end
         end

         assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (o_vld && h_vld && !ready && push) |=> ($stable(h_dat) && $stable(o_dat) && h_vld));
      end else begin : g_bare
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               o_vld <= 1'b0;
               o_dat <= '0;
            end else begin
               if (pop) o_vld <= 1'b0;
               if (push && (!o_vld || pop)) begin
                  o_vld <= 1'b1;
                  o_dat <= push_dat;
               end
            end
         end
      end
   endgenerate

   assign valid = o_vld;
   assign dat   = o_dat;

   assert_stall_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (o_vld && !ready) |=> (o_vld && $stable(o_dat)));

endmodule

// File: rtl/bus_instr_framer.sv
module bus_instr_framer
   import framer_pkg::*;
#(
   parameter int DW             = 8,
   parameter int MAX_CYC        = 8,
   parameter bit SAMPLE_ON_FALL = 1'b1,
   parameter bit USE_HOLD       = 1'b1,
   localparam int CW            = $clog2(MAX_CYC + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  phi2,
   input  logic [DW-1:0]         bus_data,
   input  logic                  bus_rnw,
   input  logic                  bus_sync,
   input  logic                  bus_rdy,
   input  logic                  rec_ready,
   output logic                  rec_valid,
   output logic [DW-1:0]         rec_opcode,
   output logic [MAX_CYC*DW-1:0] rec_data,
   output logic [MAX_CYC-1:0]    rec_rnw,
   output logic [CW-1:0]         rec_count,
   output logic                  rec_irq,
   output logic                  rec_brk,
   output logic                  rec_ovf
);

   localparam int DATA_W = MAX_CYC * DW;
   localparam int PW     = 1 + 2 + CW + MAX_CYC + DATA_W;

   generate
      if (DW < 8) begin : g_bad_dw
         $error("bus_instr_framer: DW must be at least 8");
      end
      if (MAX_CYC < 2) begin : g_bad_depth
         $error("bus_instr_framer: MAX_CYC must be at least 2");
      end
   endgenerate

   logic                  smp_vld, smp_rnw, smp_sync, smp_rdy;
   logic [DW-1:0]         smp_data;
   logic                  fin_vld, fin_ovf;
   logic [DATA_W-1:0]     fin_data;
   logic [MAX_CYC-1:0]    fin_rnw;
   logic [CW-1:0]         fin_count;
   rec_kind_e             fin_kind;
   logic [PW-1:0]         q_dat;
   logic [1:0]            q_kind;

   framer_sample #(.DW(DW), .SAMPLE_ON_FALL(SAMPLE_ON_FALL)) u_sample (
      .clk      (clk),
      .rst_n    (rst_n),
      .phi2     (phi2),
      .bus_data (bus_data),
      .bus_rnw  (bus_rnw),
      .bus_sync (bus_sync),
      .bus_rdy  (bus_rdy),
      .smp_vld  (smp_vld),
      .smp_data (smp_data),
      .smp_rnw  (smp_rnw),
      .smp_sync (smp_sync),
      .smp_rdy  (smp_rdy)
   );

   framer_assemble #(.DW(DW), .MAX_CYC(MAX_CYC), .CW(CW)) u_assemble (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_vld   (smp_vld),
      .smp_data  (smp_data),
      .smp_rnw   (smp_rnw),
      .smp_sync  (smp_sync),
      .smp_rdy   (smp_rdy),
      .fin_vld   (fin_vld),
      .fin_data  (fin_data),
      .fin_rnw   (fin_rnw),
      .fin_count (fin_count),
      .fin_kind  (fin_kind),
      .fin_ovf   (fin_ovf)
   );

   framer_outq #(.W(PW), .USE_HOLD(USE_HOLD)) u_outq (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (fin_vld),
      .push_dat ({fin_ovf, fin_kind, fin_count, fin_rnw, fin_data}),
      .ready    (rec_ready),
      .valid    (rec_valid),
      .dat      (q_dat)
   );

   assign {rec_ovf, q_kind, rec_count, rec_rnw, rec_data} = q_dat;
   assign rec_opcode = rec_data[DW-1:0];
   assign rec_irq    = (q_kind == REC_HWIRQ);
   assign rec_brk    = (q_kind == REC_SWBRK);

endmodule

// File: tb/bus_instr_framer_bench.sv
module bus_instr_framer_bench;

   typedef struct packed {
      logic [63:0] d;
      logic [7:0]  r;
      logic [3:0]  n;
      logic        irq;
      logic        brk;
      logic        ovf;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        phi2;
   logic [7:0]  bdat;
   logic        brnw, bsync, brdy, rready;
   logic        rec_valid, rec_irq, rec_brk, rec_ovf;
   logic [7:0]  rec_opcode;
   logic [63:0] rec_data;
   logic [7:0]  rec_rnw;
   logic [3:0]  rec_count;

   int    checks = 0;
   int    errors = 0;
   bit    finished = 1'b0;
   exp_t  q[$];
   string tq[$];
   exp_t  e;
   string t;

   always #4 clk = ~clk;

   bus_instr_framer u_bus_instr_framer (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .bus_data(bdat), .bus_rnw(brnw),
      .bus_sync(bsync), .bus_rdy(brdy), .rec_ready(rready), .rec_valid(rec_valid),
      .rec_opcode(rec_opcode), .rec_data(rec_data), .rec_rnw(rec_rnw),
      .rec_count(rec_count), .rec_irq(rec_irq), .rec_brk(rec_brk), .rec_ovf(rec_ovf)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic exp_rec(input string tag, input logic [63:0] d, input logic [7:0] r,
                          input logic [3:0] n, input logic irq, input logic brk, input logic ovf);
      q.push_back('{d: d, r: r, n: n, irq: irq, brk: brk, ovf: ovf});
      tq.push_back(tag);
   endtask

   // one processor cycle: phi2 high for three clocks, then low for three
   task automatic bus_cycle(input logic [7:0] d, input logic rw, input logic sy,
                            input logic rd, input bit lat = 1'b0);
      phi2 = 1'b1; bdat = d; brnw = rw; bsync = sy; brdy = rd;
      repeat (3) tick();
      phi2 = 1'b0;
      tick();
      @(negedge clk);
      if (lat) check(rec_valid == 1'b0, "R6", "valid one clock after sample", rec_valid, 0);
      tick();
      @(negedge clk);
      if (lat) check(rec_valid == 1'b1, "R6", "valid two clocks after sample", rec_valid, 1);
      tick();
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rec_valid && rready) begin
         checks++;
         if (q.size() == 0) begin
            errors++;
            $display("FAIL R10 unexpected record: actual opcode %0h expected none", rec_opcode);
         end else begin
            e = q.pop_front();
            t = tq.pop_front();
            if (rec_opcode !== e.d[7:0] ||
                {rec_data, rec_rnw, rec_count, rec_irq, rec_brk, rec_ovf} !== e) begin
               errors++;
               $display("FAIL %s record: actual %0h expected %0h", t,
                        {rec_data, rec_rnw, rec_count, rec_irq, rec_brk, rec_ovf}, e);
            end
         end
      end
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R6 watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; phi2 = 1'b1; bdat = 8'h00; brnw = 1'b1; bsync = 1'b0; brdy = 1'b1;
      rready = 1'b1;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(rec_valid == 1'b0, "R8", "no record after reset", rec_valid, 0);
      tick();

      // R8: cycles before the first fetch are dropped
      bus_cycle(8'h12, 1'b1, 1'b0, 1'b1);
      bus_cycle(8'h34, 1'b0, 1'b0, 1'b1);
      exp_rec("R2 R3 R8 immediate load", 64'h40A9, 8'h03, 4'd2, 0, 0, 0);
      bus_cycle(8'hA9, 1'b1, 1'b1, 1'b1);
      bus_cycle(8'h40, 1'b1, 1'b0, 1'b1);
      check(rec_valid == 1'b0, "R6", "no record before next fetch", rec_valid, 0);

      // R6 latency on the fetch that releases the load record
      exp_rec("R3 absolute store", 64'h400D008D, 8'h07, 4'd4, 0, 0, 0);
      bus_cycle(8'h8D, 1'b1, 1'b1, 1'b1, 1'b1);
      bus_cycle(8'h00, 1'b1, 1'b0, 1'b1);
      bus_cycle(8'h0D, 1'b1, 1'b0, 1'b1);
      bus_cycle(8'h40, 1'b0, 1'b0, 1'b1);

      // R4 wait states and R1 inputs wiggled while phi2 stays put
      exp_rec("R1 R4 wait states", 64'h77FE30AD, 8'h0F, 4'd4, 0, 0, 0);
      bus_cycle(8'hAD, 1'b1, 1'b1, 1'b1);
      bus_cycle(8'h30, 1'b1, 1'b0, 1'b1);
      bus_cycle(8'hFE, 1'b1, 1'b0, 1'b1);
      bus_cycle(8'h55, 1'b1, 1'b0, 1'b0);
      bus_cycle(8'h66, 1'b0, 1'b0, 1'b0);
      bdat = 8'h5A; bsync = 1'b1; brdy = 1'b1; brnw = 1'b0;
      repeat (6) tick();
      bus_cycle(8'h77, 1'b1, 1'b0, 1'b1);
      bus_cycle(8'h99, 1'b1, 1'b1, 1'b0);

      // R5 hardware interrupt, a wait state between the pushes
      exp_rec("R4 R5 hardware interrupt", 64'h00E000246AE35858, 8'h63, 4'd7, 1, 0, 0);
      bus_cycle(8'h58, 1'b1, 1'b1, 1'b1);
      bus_cycle(8'h58, 1'b1, 1'b0, 1'b1);
      bus_cycle(8'hE3, 1'b0, 1'b0, 1'b1);
      bus_cycle(8'h11, 1'b1, 1'b0, 1'b0);
      bus_cycle(8'h6A, 1'b0, 1'b0, 1'b1);
      bus_cycle(8'h24, 1'b0, 1'b0, 1'b1);
      bus_cycle(8'h00, 1'b1, 1'b0, 1'b1);
      bus_cycle(8'hE0, 1'b1, 1'b0, 1'b1);

      // R5 software break
      exp_rec("R5 software break", 64'h00DC00303CE50100, 8'h63, 4'd7, 0, 1, 0);
      bus_cycle(8'h00, 1'b1, 1'b1, 1'b1);
      bus_cycle(8'h01, 1'b1, 1'b0, 1'b1);
      bus_cycle(8'hE5, 1'b0, 1'b0, 1'b1);
      bus_cycle(8'h3C, 1'b0, 1'b0, 1'b1);
      bus_cycle(8'h30, 1'b0, 1'b0, 1'b1);
      bus_cycle(8'h00, 1'b1, 1'b0, 1'b1);
      bus_cycle(8'hDC, 1'b1, 1'b0, 1'b1);

      // R5 two pushes only: plain record
      exp_rec("R5 subroutine call", 64'h0000E56FE3019020, 8'h27, 4'd6, 0, 0, 0);
      bus_cycle(8'h20, 1'b1, 1'b1, 1'b1);
      bus_cycle(8'h90, 1'b1, 1'b0, 1'b1);
      bus_cycle(8'h01, 1'b1, 1'b0, 1'b1);
      bus_cycle(8'hE3, 1'b0, 1'b0, 1'b1);
      bus_cycle(8'h6F, 1'b0, 1'b0, 1'b1);
      bus_cycle(8'hE5, 1'b1, 1'b0, 1'b1);

      // R7 overflow: fetch plus nine reads
      exp_rec("R7 overflow", 64'h070605040302014C, 8'hFF, 4'd8, 0, 0, 1);
      bus_cycle(8'h4C, 1'b1, 1'b1, 1'b1);
      for (int k = 1; k <= 9; k++) bus_cycle(8'(k), 1'b1, 1'b0, 1'b1);

      // R9 R10 stalled consumer
      rready = 1'b0;
      bus_cycle(8'hC8, 1'b1, 1'b1, 1'b1);
      exp_rec("R9 held record", 64'hC8C8, 8'h03, 4'd2, 0, 0, 0);
      bus_cycle(8'hC8, 1'b1, 1'b0, 1'b1);
      @(negedge clk);
      check(rec_valid && rec_opcode == 8'h4C, "R9", "offered record during stall",
            {rec_valid, rec_opcode}, {1'b1, 8'h4C});
      tick();
      bus_cycle(8'hE8, 1'b1, 1'b1, 1'b1);
      bus_cycle(8'hE8, 1'b1, 1'b0, 1'b1);
      bus_cycle(8'hCA, 1'b1, 1'b1, 1'b1);
      bus_cycle(8'hCA, 1'b1, 1'b0, 1'b1);
      @(negedge clk);
      check(rec_valid && rec_opcode == 8'h4C && rec_ovf, "R9", "record unchanged after long stall",
            {rec_valid, rec_ovf, rec_opcode}, {1'b1, 1'b1, 8'h4C});
      tick();
      rready = 1'b1;
      repeat (4) tick();
      @(negedge clk);
      check(rec_valid == 1'b0, "R10", "record finished into full slots dropped", rec_valid, 0);
      tick();
      exp_rec("R10 next record after drop", 64'hCACA, 8'h03, 4'd2, 0, 0, 0);
      bus_cycle(8'hEA, 1'b1, 1'b1, 1'b1);
      bus_cycle(8'hEA, 1'b1, 1'b0, 1'b1);
      repeat (4) tick();
      check(q.size() == 0, "R9", "all expected records delivered", q.size(), 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule